// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data) that gives a bus master byte access to a 256-byte internal store. It oversamples both bus lines with the system clock and finds START and STOP conditions from SDA edges while SCL is high. It shifts address and data bytes in and out and pulls SDA low to acknowledge. The bus drivers sit outside the block: the block raises a pull-low enable, and the pad ties SDA to ground while that enable is high.

A write transfer sends the device address, one word-address byte and then up to a page of data bytes. The data bytes go into a page buffer. They reach the store only when the master closes the transfer with STOP. A timed internal write cycle then follows, and during it the device address goes unacknowledged, so a master can poll until the slave answers. A pointer holds the address after the last byte accessed and keeps its value from one transfer to the next. This supports current-address reads, dummy-write random reads and sequential reads that wrap around the top of the store.

Top module: `twi_mem_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the ninth clock) only a device byte whose upper seven bits equal `DEV_ADDR`. Bit 0 of that byte selects read (1) or write (0). Any other device byte gets no acknowledge, and the slave leaves SDA released until the next START.
- R2: A single data byte written after the word-address byte is stored at that address once STOP arrives, and a later read of that address returns it.
- R3: Within one write transfer, successive data bytes go to successive addresses. Only the low three address bits advance, and they wrap inside the aligned 8-byte page while the upper five bits stay fixed.
- R4: Data bytes followed by a repeated START instead of STOP are discarded: the store keeps its old contents and no internal write cycle starts.
- R5: After a STOP that commits data, the device address is not acknowledged for `BUSY_CYCLES` clock cycles, and it is acknowledged again once that time has passed.
- R6: A read with no preceding word address returns the byte at the address following the last byte read or written.
- R7: A write of the device address and word address with no data, then a repeated START and the device address with the read bit set, returns the byte at that word address.
- R8: While the master acknowledges each byte read, the slave sends the byte at the next address. Address FFh is followed by 00h. A master no-acknowledge ends the read.
- R9: After reset, SDA is released, every store byte reads 00h and the pointer is 00h.
- R10: The slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | High to pull the SDA line to ground |

## Verification
A bad bit counter or shift register shows up within one byte time as an acknowledge in the wrong clock or no acknowledge at all, and on reads as a corrupted byte. Pointer or page-slot errors stay hidden until a later read returns data from the wrong address, so every write is followed by a readback of the exact addresses involved, including the page wrap and the FFh-to-00h rollover. A busy timer of the wrong length shows up only at the poll right after the commit or at the poll after the window has ended, and the test probes both sides of that window.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } twi_state_e;

    typedef enum logic [1:0] {
        RL_DEV,
        RL_WADDR,
        RL_WDATA
    } twi_role_e;

    typedef struct packed {
        logic scl_m;
        logic scl_s;
        logic scl_p;
        logic sda_m;
        logic sda_s;
        logic sda_p;
    } twi_sync_t;

endpackage

// File: rtl/twi_bus_mon.sv
module twi_bus_mon
    import twi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    twi_sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.scl_m = scl_i;
        sync_d.scl_s = sync_q.scl_m;
        sync_d.scl_p = sync_q.scl_s;
        sync_d.sda_m = sda_i;
        sync_d.sda_s = sync_q.sda_m;
        sync_d.sda_p = sync_q.sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_o      = sync_q.scl_s;
    assign sda_o      = sync_q.sda_s;
    assign scl_rise_o = sync_q.scl_s & ~sync_q.scl_p;
    assign scl_fall_o = ~sync_q.scl_s & sync_q.scl_p;
    assign start_o    = sync_q.scl_s & sync_q.scl_p & sync_q.sda_p & ~sync_q.sda_s;
    assign stop_o     = sync_q.scl_s & sync_q.scl_p & ~sync_q.sda_p & sync_q.sda_s;

endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
    parameter  int PAGE_W = 3,
    parameter  int DATA_W = 8,
    localparam int PAGE_N = 1 << PAGE_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_i,
    input  logic                           wr_i,
    input  logic [PAGE_W-1:0]              slot_i,
    input  logic [DATA_W-1:0]              data_i,
    output logic [PAGE_N-1:0][DATA_W-1:0]  data_o,
    output logic [PAGE_N-1:0]              valid_o
);

    logic [PAGE_N-1:0][DATA_W-1:0] data_d, data_q;
    logic [PAGE_N-1:0]             valid_d, valid_q;

    always_comb begin
        data_d  = data_q;
        valid_d = valid_q;
        if (clr_i) begin
            valid_d = '0;
        end else if (wr_i) begin
            data_d[slot_i]  = data_i;
            valid_d[slot_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= '0;
        end else begin
            data_q  <= data_d;
            valid_q <= valid_d;
        end
    end

    assign data_o  = data_q;
    assign valid_o = valid_q;

    // R4
    buf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (valid_q == '0));

endmodule

// File: rtl/twi_store.sv
module twi_store #(
    parameter  int ADDR_W = 8,
    parameter  int PAGE_W = 3,
    parameter  int DATA_W = 8,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int PAGE_N = 1 << PAGE_W,
    localparam int HI_W   = ADDR_W - PAGE_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           commit_i,
    input  logic [HI_W-1:0]                page_i,
    input  logic [PAGE_N-1:0][DATA_W-1:0]  buf_data_i,
    input  logic [PAGE_N-1:0]              buf_valid_i,
    input  logic [ADDR_W-1:0]              rd_addr_i,
    output logic [DATA_W-1:0]              rd_data_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam int SLOT = g % PAGE_N;
        localparam int HI   = g / PAGE_N;
        logic [DATA_W-1:0] cell_d;

        always_comb begin
            cell_d = mem_q[g];
            if (commit_i && (page_i == HI_W'(HI)) && buf_valid_i[SLOT])
                cell_d = buf_data_i[SLOT];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= cell_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h52,
    parameter int          BUSY_CYCLES = 1000,
    parameter int          ADDR_W      = 8,
    parameter int          PAGE_W      = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);

    localparam int DATA_W = 8;
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int HI_W   = ADDR_W - PAGE_W;
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        twi_state_e          st;
        twi_role_e           role;
        logic                rd;
        logic [DATA_W-1:0]   sh;
        logic [3:0]          bitcnt;
        logic                pull;
        logic                mack;
        logic [DATA_W-1:0]   tx;
        logic [ADDR_W-1:0]   ptr;
        logic [BUSY_W-1:0]   busy;
    } regs_t;

    regs_t r_d, r_q;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic buf_clr, buf_wr, commit;
    logic [PAGE_N-1:0][DATA_W-1:0] buf_data;
    logic [PAGE_N-1:0]             buf_valid;
    logic [DATA_W-1:0]             rd_data;
    logic [PAGE_W-1:0]             slot_nx;

    twi_bus_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_lvl),
        .sda_o      (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    twi_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (buf_clr),
        .wr_i    (buf_wr),
        .slot_i  (r_q.ptr[PAGE_W-1:0]),
        .data_i  (r_q.sh),
        .data_o  (buf_data),
        .valid_o (buf_valid)
    );

    twi_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_i    (commit),
        .page_i      (r_q.ptr[ADDR_W-1:PAGE_W]),
        .buf_data_i  (buf_data),
        .buf_valid_i (buf_valid),
        .rd_addr_i   (r_q.ptr),
        .rd_data_o   (rd_data)
    );

    assign slot_nx = r_q.ptr[PAGE_W-1:0] + PAGE_W'(1);

    always_comb begin
        r_d     = r_q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        commit  = 1'b0;

        if (r_q.busy != '0) r_d.busy = r_q.busy - BUSY_W'(1);

        if (start_det) begin
            r_d.st     = ST_RX;
            r_d.role   = RL_DEV;
            r_d.rd     = 1'b0;
            r_d.bitcnt = '0;
            r_d.pull   = 1'b0;
            buf_clr    = 1'b1;
        end else if (stop_det) begin
            if ((r_q.st == ST_RX || r_q.st == ST_ACK) && r_q.role == RL_WDATA
                && (buf_valid != '0)) begin
                commit   = 1'b1;
                r_d.busy = BUSY_W'(BUSY_CYCLES);
            end
            r_d.st   = ST_IDLE;
            r_d.pull = 1'b0;
            buf_clr  = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_RX: begin
                    if (scl_rise && r_q.bitcnt < 4'd8) begin
                        r_d.sh     = {r_q.sh[DATA_W-2:0], sda_lvl};
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end else if (scl_fall && r_q.bitcnt == 4'd8) begin
                        r_d.st   = ST_ACK;
                        r_d.pull = 1'b1;
                        unique case (r_q.role)
                            RL_DEV: begin
                                if (r_q.sh[7:1] == DEV_ADDR && r_q.busy == '0) begin
                                    r_d.rd   = r_q.sh[0];
                                    r_d.role = r_q.sh[0] ? RL_DEV : RL_WADDR;
                                end else begin
                                    r_d.st   = ST_IDLE;
                                    r_d.pull = 1'b0;
                                end
                            end
                            RL_WADDR: begin
                                r_d.ptr  = r_q.sh[ADDR_W-1:0];
                                r_d.role = RL_WDATA;
                            end
                            default: begin
                                buf_wr  = 1'b1;
                                r_d.ptr = {r_q.ptr[ADDR_W-1:PAGE_W], slot_nx};
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.pull   = 1'b0;
                        r_d.bitcnt = '0;
                        if (r_q.rd) begin
                            r_d.st   = ST_TX;
                            r_d.tx   = rd_data;
                            r_d.ptr  = r_q.ptr + ADDR_W'(1);
                            r_d.pull = ~rd_data[DATA_W-1];
                        end else begin
                            r_d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.bitcnt == 4'd7) begin
                            r_d.pull = 1'b0;
                            r_d.st   = ST_MACK;
                        end else begin
                            r_d.tx     = {r_q.tx[DATA_W-2:0], 1'b0};
                            r_d.bitcnt = r_q.bitcnt + 4'd1;
                            r_d.pull   = ~r_q.tx[DATA_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.st     = ST_TX;
                            r_d.bitcnt = '0;
                            r_d.tx     = rd_data;
                            r_d.ptr    = r_q.ptr + ADDR_W'(1);
                            r_d.pull   = ~rd_data[DATA_W-1];
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_pull_o = r_q.pull;

    // R10
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.pull) |-> !scl_lvl);

    // R2
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> stop_det);

    // R5
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACK && $past(r_q.st) == ST_RX && $past(r_q.role) == RL_DEV)
        |-> ($past(r_q.busy) == '0));

    // R8
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_TX && $past(r_q.st) != ST_TX)
        |-> (r_q.ptr == $past(r_q.ptr) + ADDR_W'(1)));

    // R3
    page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.role == RL_WDATA && $past(r_q.role) == RL_WDATA)
        |-> (r_q.ptr[ADDR_W-1:PAGE_W] == $past(r_q.ptr[ADDR_W-1:PAGE_W])));

endmodule

// File: tb/sim_twi_mem_slave.sv
module sim_twi_mem_slave;

    localparam int BUSY = 600;
    localparam int Q    = 8;
    localparam logic [7:0] AW = 8'hA4;
    localparam logic [7:0] AR = 8'hA5;
    localparam logic [15:0] VEC [0:5] = '{16'h00A5, 16'h035A, 16'h7FC6,
                                          16'h8039, 16'hFE81, 16'hFFF1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;
    logic [7:0] model [256];
    int n_run = 0;
    int n_fail = 0;
    int r10_viol = 0;
    bit done = 1'b0;
    logic prev_pull = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    twi_mem_slave #(.DEV_ADDR(7'h52), .BUSY_CYCLES(BUSY)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull)
    );

    always @(negedge clk) begin
        if (sda_pull && !prev_pull && scl) r10_viol++;
        prev_pull <= sda_pull;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic q_wait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q_wait();
        scl = 1'b1;   q_wait();
        sda_m = 1'b0; q_wait();
        scl = 1'b0;   q_wait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q_wait();
        scl = 1'b1;   q_wait();
        sda_m = 1'b1; q_wait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q_wait();
            scl = 1'b1; q_wait(); q_wait();
            scl = 1'b0; q_wait();
        end
        sda_m = 1'b1; q_wait();
        scl = 1'b1;   q_wait();
        ack = ~sda_line; q_wait();
        scl = 1'b0;   q_wait();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q_wait();
            scl = 1'b1; q_wait();
            b[i] = sda_line; q_wait();
            scl = 1'b0; q_wait();
        end
        sda_m = ~give_ack; q_wait();
        scl = 1'b1; q_wait(); q_wait();
        scl = 1'b0; q_wait();
        sda_m = 1'b1;
    endtask

    task automatic wr_seq(input logic [7:0] a, input int n, input logic [7:0] first,
                          input string req);
        logic ack;
        bus_start();
        send_byte(AW, ack); check({req, " dev ack"}, {7'b0, ack}, 8'h01);
        send_byte(a, ack);
        for (int i = 0; i < n; i++) begin
            logic [2:0] lo;
            lo = a[2:0] + 3'(i);
            send_byte(first + 8'(i), ack);
            model[{a[7:3], lo}] = first + 8'(i);
        end
        bus_stop();
    endtask

    task automatic rd_rand(input logic [7:0] a, input int n, input string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(AW, ack);
        send_byte(a, ack);
        bus_start();
        send_byte(AR, ack); check({req, " read ack"}, {7'b0, ack}, 8'h01);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            check(req, b, model[8'(a + 8'(i))]);
        end
        bus_stop();
    endtask

    task automatic rd_cur(input logic [7:0] exp, input string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(AR, ack); check({req, " cur ack"}, {7'b0, ack}, 8'h01);
        recv_byte(1'b0, b);
        check(req, b, exp);
        bus_stop();
    endtask

    task automatic wait_busy();
        repeat (BUSY + 100) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R9 reset state
        check("R9 pull after reset", {7'b0, sda_pull}, 8'h00);
        rd_cur(8'h00, "R9 pointer and store after reset");

        // R1 address mismatch
        bus_start();
        send_byte(8'hA6, ack); check("R1 wrong addr write", {7'b0, ack}, 8'h00);
        bus_stop();
        bus_start();
        send_byte(8'h25, ack); check("R1 wrong addr read", {7'b0, ack}, 8'h00);
        bus_stop();

        // R2 R7 vector table walk
        for (int i = 0; i < 6; i++) begin
            wr_seq(VEC[i][15:8], 1, VEC[i][7:0], "R2");
            wait_busy();
            rd_rand(VEC[i][15:8], 1, "R2 R7 readback");
        end

        // R5 busy polling
        wr_seq(8'h20, 1, 8'h77, "R5");
        bus_start();
        send_byte(AW, ack); check("R5 poll during busy", {7'b0, ack}, 8'h00);
        bus_stop();
        wait_busy();
        bus_start();
        send_byte(AW, ack); check("R5 poll after busy", {7'b0, ack}, 8'h01);
        bus_stop();
        rd_rand(8'h20, 1, "R5 data");

        // R3 page write wrap, R8 sequential read
        wr_seq(8'h45, 8, 8'h10, "R3");
        wait_busy();
        rd_rand(8'h40, 9, "R3 R8 page");

        // R6 current-address read
        wr_seq(8'h30, 2, 8'hC3, "R6");
        wait_busy();
        rd_rand(8'h30, 1, "R6 setup");
        rd_cur(model[8'h31], "R6 current");

        // R4 repeated START discards buffered data
        bus_start();
        send_byte(AW, ack);
        send_byte(8'h60, ack);
        send_byte(8'hEE, ack);
        bus_start();
        send_byte(AR, ack); check("R4 restart ack", {7'b0, ack}, 8'h01);
        recv_byte(1'b0, b);
        check("R4 read after discard", b, model[8'h61]);
        bus_stop();
        bus_start();
        send_byte(AW, ack); check("R4 no busy", {7'b0, ack}, 8'h01);
        bus_stop();
        rd_rand(8'h60, 1, "R4 store kept");

        // R8 wrap FFh -> 00h
        rd_rand(8'hFF, 2, "R8 wrap");

        // R10 pull timing
        check("R10 pull rises with scl low", 8'(r10_viol), 8'h00);

        // R9 reset clears store and pointer
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        check("R9 pull after second reset", {7'b0, sda_pull}, 8'h00);
        rd_cur(8'h00, "R9 second reset");
        rd_rand(8'hFF, 1, "R9 top cleared");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule